// File: doc/BRIEF.md
# Watchdog Timer with Protected Status Flags

This block guards a small processor core against runaway code. A free-running divider derives an instruction-rate tick from the system clock, one tick per four clocks, and a two-stage counting chain counts those ticks. If software fails to service the timer within a configurable window of 2^n ticks, where n runs from 8 to 11, the block emits a one-cycle chip-reset pulse and records the event in a time-out flag.

Instruction decode drives the strobes into the block. A single-cycle strobe marks each clear instruction and another marks the halt instruction. A configuration input chooses one of two clear modes. In the first, one clear instruction restarts the window. In the second, two different clear instructions must both have been executed, in either order. Halt always restarts the window and marks the power-down state.

The block also holds the processor's status byte. The core may write that byte at any time, but the time-out and power-down bits are protected and move only on the hardware events listed below. A configuration input disables the whole timer.

Top module: `wdog_top`

## Requirements
- R1: The counting chain advances only on the instruction tick, which is asserted on one system clock in every four, counted from the release of reset.
- R2: With the timer enabled and no clear or halt, `chip_rst_o` pulses high for exactly one cycle every 2^(8+`cfg_exp_sel`) ticks, which is 4·2^(8+`cfg_exp_sel`) system clocks, and the count then restarts from zero.
- R3: In single-clear mode (`cfg_two_clr`=0), a `clr_one_i` strobe zeroes the count and clears both the time-out and power-down flags on the next edge. In this mode `clr_a_i` and `clr_b_i` have no effect.
- R4: In paired-clear mode (`cfg_two_clr`=1), the count and both flags are cleared only once both `clr_a_i` and `clr_b_i` have been seen. They may arrive in either order or in the same cycle. A repeated `clr_a_i` (or `clr_b_i`) does not complete the pair, and `clr_one_i` has no effect in this mode.
- R5: Pair tracking is discarded after a completed clear, on halt and on reset, so a later single strobe of the other kind does not complete a pair.
- R6: A `halt_i` strobe zeroes the count, sets the power-down flag and clears the time-out flag on the next edge. It takes priority over a clear or a timeout in the same cycle.
- R7: With `cfg_en`=0 the count is held at zero, no reset pulse is ever produced and clear strobes leave both flags unchanged. Halt still sets the power-down flag.
- R8: A timeout sets the time-out flag and leaves the power-down flag unchanged.
- R9: Synchronous reset clears the count, the pulse, both flags and the writable status bits.
- R10: `status_o` shows the time-out flag in bit 4 and the power-down flag in bit 5. A `stat_wr_i` write loads every other bit from `stat_wdata_i` on the next edge and never changes bits 4 and 5.
- R11: A clear or halt that lands in the same cycle as the final tick of a window suppresses that timeout, so no pulse is produced and the time-out flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| cfg_en | input | 1 | Timer enable |
| cfg_two_clr | input | 1 | 0: single-clear mode, 1: paired-clear mode |
| cfg_exp_sel | input | 2 | Timeout exponent n = 8 + value |
| clr_one_i | input | 1 | Single clear instruction strobe |
| clr_a_i | input | 1 | First-kind paired clear strobe |
| clr_b_i | input | 1 | Second-kind paired clear strobe |
| halt_i | input | 1 | Halt instruction strobe |
| stat_wr_i | input | 1 | Status byte write strobe |
| stat_wdata_i | input | 8 | Status byte write data |
| chip_rst_o | output | 1 | One-cycle chip reset request on timeout |
| to_flag_o | output | 1 | Time-out flag |
| pdf_flag_o | output | 1 | Power-down flag |
| status_o | output | 8 | Status byte with protected flags in bits 4 and 5 |

## Verification
The assertions watch, on every cycle, that the reset pulse is never longer than one cycle and never appears while the timer is disabled. They also check that the prescaler holds still between ticks, that halt always leaves power-down set and time-out cleared, that a status write alone leaves the protected flags unchanged, and that pair tracking is empty after a completed clear. The window length for each exponent, the ordering of paired clears, the rejection of a repeated half-pair, and the suppression of a timeout by a clear landing on the final tick are sequence properties. Only the bench scenarios show these, driven against a per-cycle reference model.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int STAT_W  = 8;
  localparam int TO_BIT  = 4;
  localparam int PDF_BIT = 5;

  typedef enum logic {
    CLR_SINGLE = 1'b0,
    CLR_PAIR   = 1'b1
  } clr_mode_e;
endpackage

// File: rtl/wdog_tick.sv
module wdog_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/wdog_clear_ctl.sv
module wdog_clear_ctl
  import wdog_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic two_clr_i,
  input  logic clr_one_i,
  input  logic clr_a_i,
  input  logic clr_b_i,
  input  logic halt_i,
  output logic done_o,
  output logic wipe_o
);
  clr_mode_e mode;
  logic seen_a_q, seen_b_q;
  logic pair_done, single_done;

  assign mode        = two_clr_i ? CLR_PAIR : CLR_SINGLE;
  assign single_done = en_i && (mode == CLR_SINGLE) && clr_one_i;
  assign pair_done   = en_i && (mode == CLR_PAIR) &&
                       (seen_a_q || clr_a_i) && (seen_b_q || clr_b_i);
  assign done_o      = single_done || pair_done;
  assign wipe_o      = en_i && (halt_i || done_o);

  always_ff @(posedge clk) begin
    if (rst || !en_i || (mode != CLR_PAIR) || halt_i || done_o) begin
      seen_a_q <= 1'b0;
      seen_b_q <= 1'b0;
    end else begin
      seen_a_q <= seen_a_q || clr_a_i;
      seen_b_q <= seen_b_q || clr_b_i;
    end
  end

  assert_pair_cleared_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !(seen_a_q || seen_b_q));
endmodule

// File: rtl/wdog_chain.sv
module wdog_chain #(
  parameter int PRE_W = 8,
  parameter int POST_W = 3,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             wipe_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tout_o,
  output logic             chip_rst_o
);
  localparam logic [PRE_W-1:0] PRE_MAX = '1;

  logic [PRE_W-1:0]  pre_q;
  logic [POST_W-1:0] post_q;
  logic [POST_W-1:0] post_lim;
  logic              carry;
  logic              chip_rst_q;

  always_comb begin
    post_lim = POST_W'((1 << sel_i) - 1);
  end

  assign carry  = tick_i && (pre_q == PRE_MAX);
  assign tout_o = en_i && !wipe_i && carry && (post_q == post_lim);

  always_ff @(posedge clk) begin
    if (rst || !en_i || wipe_i) begin
      pre_q  <= '0;
      post_q <= '0;
    end else if (tick_i) begin
      pre_q <= pre_q + 1'b1;
      if (carry) begin
        post_q <= (post_q == post_lim) ? '0 : post_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chip_rst_q <= 1'b0;
    end else begin
      chip_rst_q <= tout_o;
    end
  end

  assign chip_rst_o = chip_rst_q;

  assert_hold_between_ticks_R1: assert property (@(posedge clk) disable iff (rst)
    (en_i && !tick_i && !wipe_i) |=> $stable(pre_q));
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    chip_rst_q |=> !chip_rst_q);
endmodule

// File: rtl/wdog_flags.sv
module wdog_flags
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_i,
  input  logic              done_i,
  input  logic              tout_i,
  input  logic              wr_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic              to_o,
  output logic              pdf_o,
  output logic [STAT_W-1:0] status_o
);
  logic to_q, pdf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      to_q  <= 1'b0;
      pdf_q <= 1'b0;
    end else if (halt_i) begin
      to_q  <= 1'b0;
      pdf_q <= 1'b1;
    end else if (done_i) begin
      to_q  <= 1'b0;
      pdf_q <= 1'b0;
    end else if (tout_i) begin
      to_q  <= 1'b1;
    end
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (i == TO_BIT) begin : g_to
      assign status_o[i] = to_q;
    end else if (i == PDF_BIT) begin : g_pdf
      assign status_o[i] = pdf_q;
    end else begin : g_rw
      logic b_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          b_q <= 1'b0;
        end else if (wr_i) begin
          b_q <= wdata_i[i];
        end
      end
      assign status_o[i] = b_q;
    end
  end

  assign to_o  = to_q;
  assign pdf_o = pdf_q;

  assert_halt_sets_pdf_R6: assert property (@(posedge clk) disable iff (rst)
    halt_i |=> (pdf_q && !to_q));
  assert_tout_sets_to_R8: assert property (@(posedge clk) disable iff (rst)
    (tout_i && !halt_i) |=> to_q);
  assert_write_keeps_flags_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !halt_i && !done_i && !tout_i) |=> ($stable(to_q) && $stable(pdf_q)));
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int DIV    = 4,
  parameter int PRE_W  = 8,
  parameter int POST_W = 3,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              cfg_two_clr,
  input  logic [SEL_W-1:0]  cfg_exp_sel,
  input  logic              clr_one_i,
  input  logic              clr_a_i,
  input  logic              clr_b_i,
  input  logic              halt_i,
  input  logic              stat_wr_i,
  input  logic [STAT_W-1:0] stat_wdata_i,
  output logic              chip_rst_o,
  output logic              to_flag_o,
  output logic              pdf_flag_o,
  output logic [STAT_W-1:0] status_o
);
  logic tick, done, wipe, tout;

  wdog_tick #(.DIV(DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  wdog_clear_ctl u_clr (
    .clk       (clk),
    .rst       (rst),
    .en_i      (cfg_en),
    .two_clr_i (cfg_two_clr),
    .clr_one_i (clr_one_i),
    .clr_a_i   (clr_a_i),
    .clr_b_i   (clr_b_i),
    .halt_i    (halt_i),
    .done_o    (done),
    .wipe_o    (wipe)
  );

  wdog_chain #(.PRE_W(PRE_W), .POST_W(POST_W), .SEL_W(SEL_W)) u_chain (
    .clk        (clk),
    .rst        (rst),
    .en_i       (cfg_en),
    .tick_i     (tick),
    .wipe_i     (wipe),
    .sel_i      (cfg_exp_sel),
    .tout_o     (tout),
    .chip_rst_o (chip_rst_o)
  );

  wdog_flags u_flags (
    .clk      (clk),
    .rst      (rst),
    .halt_i   (halt_i),
    .done_i   (done),
    .tout_i   (tout),
    .wr_i     (stat_wr_i),
    .wdata_i  (stat_wdata_i),
    .to_o     (to_flag_o),
    .pdf_o    (pdf_flag_o),
    .status_o (status_o)
  );

  assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> !chip_rst_o);
endmodule

// File: tb/wdog_top_bench.sv
`timescale 1ns/1ps
module wdog_top_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en = 1'b0, cfg_two_clr = 1'b0;
  logic [1:0] cfg_exp_sel = 2'd0;
  logic clr_one_i = 1'b0, clr_a_i = 1'b0, clr_b_i = 1'b0, halt_i = 1'b0;
  logic stat_wr_i = 1'b0;
  logic [7:0] stat_wdata_i = 8'h00;
  logic chip_rst_o, to_flag_o, pdf_flag_o;
  logic [7:0] status_o;

  always #2 clk = ~clk;

  wdog_top u_wdog_top (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_two_clr(cfg_two_clr),
    .cfg_exp_sel(cfg_exp_sel), .clr_one_i(clr_one_i), .clr_a_i(clr_a_i),
    .clr_b_i(clr_b_i), .halt_i(halt_i), .stat_wr_i(stat_wr_i),
    .stat_wdata_i(stat_wdata_i), .chip_rst_o(chip_rst_o),
    .to_flag_o(to_flag_o), .pdf_flag_o(pdf_flag_o), .status_o(status_o)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit run = 1'b0;

  // behavioural reference model
  int m_div = 0, m_cnt = 0;
  bit m_sa = 0, m_sb = 0, m_to = 0, m_pdf = 0, m_pulse = 0;
  logic [7:0] m_ord = 8'h00;

  always @(posedge clk) begin
    bit tk, dn, wp, tout;
    int lim;
    cyc++;
    if (rst) begin
      m_div = 0; m_cnt = 0; m_sa = 0; m_sb = 0;
      m_to = 0; m_pdf = 0; m_pulse = 0; m_ord = 8'h00;
    end else begin
      tk = (m_div == 3);
      m_div = (m_div + 1) % 4;
      lim = (1 << (8 + cfg_exp_sel)) - 1;
      if (cfg_two_clr) dn = cfg_en && (m_sa || clr_a_i) && (m_sb || clr_b_i);
      else             dn = cfg_en && clr_one_i;
      wp = cfg_en && (halt_i || dn);
      tout = cfg_en && !wp && tk && (m_cnt == lim);
      m_pulse = tout;
      if (!cfg_en || wp) m_cnt = 0;
      else if (tk) m_cnt = tout ? 0 : m_cnt + 1;
      if (!cfg_en || !cfg_two_clr || halt_i || dn) begin
        m_sa = 0; m_sb = 0;
      end else begin
        m_sa = m_sa || clr_a_i; m_sb = m_sb || clr_b_i;
      end
      if (halt_i) begin m_pdf = 1; m_to = 0; end
      else if (dn) begin m_pdf = 0; m_to = 0; end
      else if (tout) m_to = 1;
      if (stat_wr_i) m_ord = stat_wdata_i & 8'hCF;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      check("R2 R11 model pulse", chip_rst_o, m_pulse);
      check("R8 model time-out flag", to_flag_o, m_to);
      check("R6 model power-down flag", pdf_flag_o, m_pdf);
      check("R10 model status", status_o, m_ord | (8'(m_to) << 4) | (8'(m_pdf) << 5));
    end
  end

  task automatic wait_pulse(output int at);
    at = -1;
    for (int i = 0; i < 9000; i++) begin
      @(negedge clk);
      if (chip_rst_o) begin at = cyc; break; end
    end
  endtask

  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: clr_one_i = 1'b1;
      1: clr_a_i = 1'b1;
      2: clr_b_i = 1'b1;
      3: halt_i = 1'b1;
      default: begin clr_a_i = 1'b1; clr_b_i = 1'b1; end
    endcase
    @(negedge clk);
    clr_one_i = 1'b0; clr_a_i = 1'b0; clr_b_i = 1'b0; halt_i = 1'b0;
  endtask

  initial begin
    int t1, t2, cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    run = 1'b1;
    @(negedge clk);
    check("R9 reset pulse", chip_rst_o, 0);
    check("R9 reset to", to_flag_o, 0);
    check("R9 reset pdf", pdf_flag_o, 0);
    check("R9 reset status", status_o, 0);

    // R1 R2: window of 2^8 ticks
    cfg_en = 1'b1;
    wait_pulse(t1);
    wait_pulse(t2);
    check("R1 R2 period n=8", t2 - t1, 1024);
    check("R8 to set after timeout", to_flag_o, 1);
    check("R8 pdf unchanged", pdf_flag_o, 0);

    // R3: paired strobes ignored in single mode
    strobe(1); strobe(2); strobe(4);
    check("R3 pair strobes ignored", to_flag_o, 1);
    strobe(0);
    check("R3 single clear", to_flag_o, 0);

    // R2: n=9
    @(negedge clk);
    cfg_exp_sel = 2'd1; clr_one_i = 1'b1;
    @(negedge clk);
    clr_one_i = 1'b0;
    wait_pulse(t1);
    wait_pulse(t2);
    check("R2 period n=9", t2 - t1, 2048);

    // R4: paired mode
    cfg_two_clr = 1'b1;
    strobe(1); strobe(1); strobe(0);
    check("R4 repeat and single ignored", to_flag_o, 1);
    strobe(2);
    check("R4 pair a then b", to_flag_o, 0);

    // R5: halt discards tracking
    strobe(1);
    strobe(3);
    check("R6 halt pdf", pdf_flag_o, 1);
    check("R6 halt to", to_flag_o, 0);
    wait_pulse(t1);
    check("R8 timeout keeps pdf", pdf_flag_o, 1);
    strobe(2);
    check("R5 halt reset pairing", to_flag_o, 1);
    strobe(1);
    check("R4 pair b then a", to_flag_o, 0);
    check("R4 pair clears pdf", pdf_flag_o, 0);

    // R5: completion discards tracking
    wait_pulse(t1);
    strobe(2);
    check("R5 completion reset pairing", to_flag_o, 1);
    strobe(4);
    check("R4 same-cycle pair", to_flag_o, 0);

    // R11: clear landing on the final tick
    cfg_two_clr = 1'b0;
    cnt = 0;
    while (!(m_div == 3 && m_cnt == (1 << (8 + cfg_exp_sel)) - 1) && cnt < 9000) begin
      @(negedge clk); cnt++;
    end
    clr_one_i = 1'b1;
    @(negedge clk);
    clr_one_i = 1'b0;
    check("R11 pulse suppressed", chip_rst_o, 0);
    check("R11 to not set", to_flag_o, 0);

    // R10: status write
    @(negedge clk);
    stat_wr_i = 1'b1; stat_wdata_i = 8'hFF;
    @(negedge clk);
    stat_wr_i = 1'b0;
    check("R10 write ordinary bits", status_o & 8'hCF, 8'hCF);
    check("R10 write keeps to", status_o[4], 0);
    check("R10 write keeps pdf", status_o[5], 0);

    // R7: disabled timer
    wait_pulse(t1);
    cfg_en = 1'b0;
    cnt = 0;
    for (int i = 0; i < 2500; i++) begin
      @(negedge clk);
      if (chip_rst_o) cnt++;
    end
    check("R7 no pulse when disabled", cnt, 0);
    strobe(0);
    check("R7 clear ignored when disabled", to_flag_o, 1);
    strobe(3);
    check("R7 halt still sets pdf", pdf_flag_o, 1);

    run = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule